// File: doc/BRIEF.md
# Exception Entry Sequencer with Delay-Slot Deferral

This block runs the processor side of taking an exception. Five request lines come in, one per source: address error, RAM error, floating-point exception, register bank overflow and interrupt. Each request is latched into a pending set. The decode stage reports whether it is handing over an instruction (`dec_valid`) and whether that instruction sits in the slot of a delayed branch (`dec_in_slot`). A pending exception is taken only on a decode that is valid and not in a slot. A request that shows up right after a delayed branch therefore waits until the first instruction that allows acceptance.

When it accepts, the block captures the vector base, stack pointer, status word and next-instruction PC. It then steps through a fixed sequence on a single memory request port. First it reads the handler address from vector base plus the source's offset. Next it writes SR one word below the stack pointer, then writes PC one more word below. Finally it issues a one-cycle fetch redirect to the handler and loads the stack pointer 8 lower. `busy` stalls the pipeline from the accepting cycle through the redirect cycle.

States: `ST_IDLE` waits for an acceptable decode. `ST_VEC` reads the vector. `ST_PUSH_SR` and `ST_PUSH_PC` write the stack. `ST_REDIR` issues the redirect. The transitions are: IDLE→VEC on accept, VEC→PUSH_SR, PUSH_SR→PUSH_PC and PUSH_PC→REDIR on each `mem_ready`, and REDIR→IDLE unconditionally.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is held, and right after it, `busy`, `mem_req`, `redir_valid` and `sp_load` are 0.
- R2: A request that is pending while the decoded instruction has `dec_in_slot`=1 is not taken. `busy` stays 0 and no memory access starts until a decode with `dec_valid`=1 and `dec_in_slot`=0 arrives.
- R3: On acceptance, the first access is a read (`mem_we`=0) at `vbr` plus the source offset. Request bit 0 (address error) uses 0x24, bit 1 (RAM error) 0x28, bit 2 (floating point) 0x34, bit 3 (bank overflow) 0x3C and bit 4 (interrupt) 0x40. A request can be accepted in the same cycle it arrives.
- R4: When several requests are pending, the lowest-numbered bit is served first. The others stay pending.
- R5: The vector read is followed by a write of SR at SP−4, then a write of PC at SP−8. SR, SP and PC are the values present in the accepting cycle; later changes on those inputs have no effect.
- R6: After the PC write, `redir_valid` is 1 for exactly one cycle with `redir_pc` equal to the word read from the vector. In the same cycle `sp_load`=1 and `sp_new`=SP−8.
- R7: While `mem_req`=1 and `mem_ready`=0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R8: Requests arriving while an entry is in progress are kept and served by a later acceptable decode, not dropped.
- R9: `busy` is 1 from the accepting cycle through the redirect cycle and 0 in the cycle after it if nothing new is accepted.
- R10: With accept in cycle A and W wait cycles on each access, the redirect occurs in cycle A+4+3W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 5 | Exception request pulses, bit per source (see R3) |
| dec_valid | input | 1 | An instruction is decoded this cycle |
| dec_in_slot | input | 1 | The decoded instruction is in a delayed-branch slot |
| vbr | input | 32 | Vector base |
| sp | input | 32 | Current stack pointer |
| sr | input | 32 | Current status word |
| pc_next | input | 32 | Address of the instruction after the last executed |
| busy | output | 1 | Pipeline stall during entry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_pc | output | 32 | Handler address |
| sp_load | output | 1 | Load new stack pointer |
| sp_new | output | 32 | Stack pointer after the two pushes |

## Verification
A wrong state encoding or a wrong transition shows up within one access. It appears as a write where the vector read belongs, as addresses out of the SP−4/SP−8 order, or as a redirect that comes early, late or twice. A corrupted pending set shows up at the next acceptable decode: a source is skipped, served out of priority order, or served when nothing was requested. Because the bench times the redirect against the accept cycle, one extra or missing state changes the measured cycle count.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int SRC_COUNT = 5;
    localparam int SRC_IW    = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VEC,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_REDIR
    } seq_state_t;

    // Vector table offset for each request bit.
    function automatic logic [7:0] vec_offset(input logic [SRC_IW-1:0] idx);
        logic [7:0] off;
        case (idx)
            3'd0:    off = 8'h24;
            3'd1:    off = 8'h28;
            3'd2:    off = 8'h34;
            3'd3:    off = 8'h3C;
            3'd4:    off = 8'h40;
            default: off = 8'h40;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/exc_pend.sv
module exc_pend #(
    parameter int NSRC = 5,
    parameter int IW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            take_i,
    output logic            any_o,
    output logic [IW-1:0]   grant_idx_o
);

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] eff;
    logic [NSRC-1:0] grant_oh;

    assign eff   = pend_q | req_i;
    assign any_o = |eff;

    // Lowest-numbered source wins: scan downward so the last hit is the lowest.
    always_comb begin
        grant_idx_o = '0;
        grant_oh    = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (eff[i]) begin
                grant_idx_o = IW'(i);
                grant_oh    = NSRC'(1) << i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (take_i) begin
            pend_q <= eff & ~grant_oh;
        end else begin
            pend_q <= eff;
        end
    end

endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
    import exc_seq_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [XLEN-1:0] vec_addr_i,
    input  logic [XLEN-1:0] sp_i,
    input  logic [XLEN-1:0] sr_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    input  logic            mem_ready_i,
    output seq_state_t      state_o,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [XLEN-1:0] mem_wdata_o,
    output logic            redir_valid_o,
    output logic [XLEN-1:0] redir_pc_o,
    output logic            sp_load_o,
    output logic [XLEN-1:0] sp_new_o
);

    localparam logic [XLEN-1:0] STEP_W  = XLEN'(STEP);
    localparam logic [XLEN-1:0] FRAME_W = XLEN'(2 * STEP);

    seq_state_t state_q, state_d;
    logic [XLEN-1:0] vec_q, sp_q, sr_q, pc_q, hdl_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)     state_d = ST_VEC;
            ST_VEC:     if (mem_ready_i) state_d = ST_PUSH_SR;
            ST_PUSH_SR: if (mem_ready_i) state_d = ST_PUSH_PC;
            ST_PUSH_PC: if (mem_ready_i) state_d = ST_REDIR;
            ST_REDIR:                    state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Context capture at acceptance, handler capture on vector read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            sp_q  <= '0;
            sr_q  <= '0;
            pc_q  <= '0;
            hdl_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                vec_q <= vec_addr_i;
                sp_q  <= sp_i;
                sr_q  <= sr_i;
                pc_q  <= pc_i;
            end
            if (state_q == ST_VEC && mem_ready_i) begin
                hdl_q <= mem_rdata_i;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req_o     = 1'b0;
        mem_we_o      = 1'b0;
        mem_addr_o    = '0;
        mem_wdata_o   = '0;
        redir_valid_o = 1'b0;
        redir_pc_o    = hdl_q;
        sp_load_o     = 1'b0;
        sp_new_o      = sp_q - FRAME_W;
        unique case (state_q)
            ST_IDLE: ;
            ST_VEC: begin
                mem_req_o  = 1'b1;
                mem_addr_o = vec_q;
            end
            ST_PUSH_SR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_q - STEP_W;
                mem_wdata_o = sr_q;
            end
            ST_PUSH_PC: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_q - FRAME_W;
                mem_wdata_o = pc_q;
            end
            ST_REDIR: begin
                redir_valid_o = 1'b1;
                sp_load_o     = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int STEP = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_COUNT-1:0] exc_req,
    input  logic                 dec_valid,
    input  logic                 dec_in_slot,
    input  logic [XLEN-1:0]      vbr,
    input  logic [XLEN-1:0]      sp,
    input  logic [XLEN-1:0]      sr,
    input  logic [XLEN-1:0]      pc_next,
    output logic                 busy,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [XLEN-1:0]      mem_addr,
    output logic [XLEN-1:0]      mem_wdata,
    input  logic [XLEN-1:0]      mem_rdata,
    input  logic                 mem_ready,
    output logic                 redir_valid,
    output logic [XLEN-1:0]      redir_pc,
    output logic                 sp_load,
    output logic [XLEN-1:0]      sp_new
);

    logic              any_pend;
    logic [SRC_IW-1:0] grant_idx;
    logic              accept;
    logic              fsm_idle;
    logic [XLEN-1:0]   vec_addr;
    seq_state_t        state;

    assign fsm_idle = (state == ST_IDLE);
    assign accept   = fsm_idle && dec_valid && !dec_in_slot && any_pend;
    assign busy     = accept || !fsm_idle;
    assign vec_addr = vbr + XLEN'(vec_offset(grant_idx));

    exc_pend #(
        .NSRC (SRC_COUNT),
        .IW   (SRC_IW)
    ) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (exc_req),
        .take_i      (accept),
        .any_o       (any_pend),
        .grant_idx_o (grant_idx)
    );

    exc_fsm #(
        .XLEN (XLEN),
        .STEP (STEP)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (accept),
        .vec_addr_i    (vec_addr),
        .sp_i          (sp),
        .sr_i          (sr),
        .pc_i          (pc_next),
        .mem_rdata_i   (mem_rdata),
        .mem_ready_i   (mem_ready),
        .state_o       (state),
        .mem_req_o     (mem_req),
        .mem_we_o      (mem_we),
        .mem_addr_o    (mem_addr),
        .mem_wdata_o   (mem_wdata),
        .redir_valid_o (redir_valid),
        .redir_pc_o    (redir_pc),
        .sp_load_o     (sp_load),
        .sp_new_o      (sp_new)
    );

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            idle,
    input logic            dec_in_slot,
    input logic            mem_req,
    input logic            mem_ready,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            redir_valid
);

    assert_slot_defers_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_in_slot && !busy) |=> !mem_req);

    assert_first_is_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && busy) |=> (mem_req && !mem_we));

    assert_redir_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> $past(mem_req && mem_ready && mem_we));

    assert_redir_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid);

    assert_hold_on_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    assert_busy_span_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || redir_valid) |-> busy);

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .idle        (fsm_idle),
    .dec_in_slot (dec_in_slot),
    .mem_req     (mem_req),
    .mem_ready   (mem_ready),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .redir_valid (redir_valid)
);

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  exc_req = '0;
    logic        dec_valid = 1'b0;
    logic        dec_in_slot = 1'b0;
    logic [31:0] vbr = 32'h0000_1000;
    logic [31:0] sp = 32'h0000_8000;
    logic [31:0] sr = 32'h0000_00F0;
    logic [31:0] pc_next = 32'h0000_2222;
    logic        busy, mem_req, mem_we, redir_valid, sp_load;
    logic [31:0] mem_addr, mem_wdata, redir_pc, sp_new;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int waits = 0;
    int wcnt = 0;
    int cyc = 0;
    bit done = 0;

    logic        log_we [0:63];
    logic [31:0] log_addr [0:63];
    logic [31:0] log_data [0:63];
    int log_n = 0;
    logic [31:0] rd_pc [0:15];
    logic [31:0] rd_sp [0:15];
    int rd_cyc [0:15];
    int rd_n = 0;
    int acc_cyc [0:15];
    int acc_n = 0;
    logic busy_q = 1'b0;
    logic hold_v = 1'b0;
    logic [31:0] hold_addr, hold_data;
    logic hold_we;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .dec_valid(dec_valid),
        .dec_in_slot(dec_in_slot), .vbr(vbr), .sp(sp), .sr(sr), .pc_next(pc_next),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .sp_load(sp_load),
        .sp_new(sp_new)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] hdl_of(input logic [31:0] a);
        return {a[27:0], 4'h0} ^ 32'h5A00_0000;
    endfunction

    function automatic logic [31:0] off_of(input int idx);
        case (idx)
            0: return 32'h24;
            1: return 32'h28;
            2: return 32'h34;
            3: return 32'h3C;
            default: return 32'h40;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory responder and port monitor, sampled 2 ns after the falling edge
    always @(negedge clk) begin
        #2;
        cyc++;
        mem_ready = mem_req && (wcnt >= waits);
        mem_rdata = hdl_of(mem_addr);
        #1;
        if (rst_n) begin
            if (hold_v) begin
                check(mem_req && mem_addr == hold_addr && mem_wdata == hold_data
                      && mem_we == hold_we, "R7", "request held during wait",
                      mem_addr, hold_addr);
            end
            if (mem_req && !mem_ready) begin
                hold_v = 1'b1; hold_addr = mem_addr; hold_data = mem_wdata; hold_we = mem_we;
                wcnt++;
            end else begin
                hold_v = 1'b0;
            end
            if (mem_req && mem_ready) begin
                log_we[log_n] = mem_we; log_addr[log_n] = mem_addr; log_data[log_n] = mem_wdata;
                log_n++;
                wcnt = 0;
            end
            if (redir_valid) begin
                rd_pc[rd_n] = redir_pc; rd_sp[rd_n] = sp_load ? sp_new : 32'hDEAD_DEAD;
                rd_cyc[rd_n] = cyc; rd_n++;
            end
            if (busy && !busy_q) begin
                acc_cyc[acc_n] = cyc; acc_n++;
            end
            busy_q = busy;
        end
    end

    // One full entry: raise src_bits with a permitting decode, pulse mid_bits during entry.
    task automatic do_entry(input logic [4:0] src_bits, input logic [4:0] mid_bits,
                            input int exp_idx, input int wt, input string req);
        int l0 = log_n;
        int r0 = rd_n;
        int a0 = acc_n;
        logic [31:0] s_sp = sp, s_sr = sr, s_pc = pc_next;
        logic [31:0] va = vbr + off_of(exp_idx);
        int guard = 0;
        waits = wt;
        @(negedge clk);
        exc_req = src_bits; dec_valid = 1'b1; dec_in_slot = 1'b0;
        #1 check(busy == 1'b1, "R9", "busy in accepting cycle", busy, 1);
        @(negedge clk);
        exc_req = '0; dec_valid = 1'b0;
        sp = ~s_sp; sr = ~s_sr; pc_next = ~s_pc;      // R5: must not affect entry
        @(negedge clk);
        exc_req = mid_bits;
        @(negedge clk);
        exc_req = '0;
        while (rd_n == r0 && guard < 100) begin
            @(negedge clk); guard++;
        end
        #4;
        check(rd_n == r0 + 1, req, "redirect issued", rd_n, r0 + 1);
        check(log_n == l0 + 3, "R5", "three accesses", log_n, l0 + 3);
        check(!log_we[l0] && log_addr[l0] == va, "R3", "vector read address", log_addr[l0], va);
        check(log_we[l0+1] && log_addr[l0+1] == s_sp - 4 && log_data[l0+1] == s_sr,
              "R5", "SR push", log_data[l0+1], s_sr);
        check(log_we[l0+2] && log_addr[l0+2] == s_sp - 8 && log_data[l0+2] == s_pc,
              "R5", "PC push", log_data[l0+2], s_pc);
        check(rd_pc[r0] == hdl_of(va), "R6", "redirect target", rd_pc[r0], hdl_of(va));
        check(rd_sp[r0] == s_sp - 8, "R6", "new stack pointer", rd_sp[r0], s_sp - 8);
        check(rd_cyc[r0] - acc_cyc[a0] == 4 + 3 * wt, "R10", "entry latency",
              rd_cyc[r0] - acc_cyc[a0], 4 + 3 * wt);
        @(negedge clk);
        #1;
        check(busy == 1'b0, "R9", "busy low after redirect", busy, 0);
        check(redir_valid == 1'b0, "R6", "redirect is one cycle", redir_valid, 0);
        sp = s_sp; sr = s_sr; pc_next = s_pc;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !mem_req && !redir_valid && !sp_load, "R1", "outputs in reset",
              {busy, mem_req, redir_valid, sp_load}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!busy && !mem_req && !redir_valid && !sp_load, "R1", "outputs after reset",
              {busy, mem_req, redir_valid, sp_load}, 0);
    endtask

    task automatic t_fpu_basic();
        do_entry(5'b00100, 5'b0, 2, 0, "R3");
    endtask

    task automatic t_deferral();
        @(negedge clk);
        exc_req = 5'b10000; dec_valid = 1'b1; dec_in_slot = 1'b1;
        #1 check(busy == 1'b0, "R2", "no accept in slot", busy, 0);
        @(negedge clk);
        exc_req = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            check(!busy && !mem_req, "R2", "still deferred", {busy, mem_req}, 0);
        end
        dec_valid = 1'b0; dec_in_slot = 1'b0;
        do_entry(5'b0, 5'b0, 4, 0, "R2");
    endtask

    task automatic t_wait_states();
        sp = 32'h0000_4400; sr = 32'h0000_0301; pc_next = 32'h0000_7776;
        do_entry(5'b00001, 5'b0, 0, 2, "R7");
    endtask

    task automatic t_priority();
        do_entry(5'b01010, 5'b0, 1, 0, "R4");
        do_entry(5'b0, 5'b0, 3, 1, "R4");
    endtask

    task automatic t_latched();
        do_entry(5'b10000, 5'b00100, 4, 0, "R8");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            check(!busy && !mem_req, "R8", "latched request waits for decode",
                  {busy, mem_req}, 0);
        end
        do_entry(5'b0, 5'b0, 2, 0, "R8");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fpu_basic();
        t_deferral();
        t_wait_states();
        t_priority();
        t_latched();
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule